// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block holds the time of day and the calendar date in seven byte-wide registers and advances them by one second each time a divider clocked from the time base completes a full count. The stored values are kept either as packed BCD digits or as plain binary, and hours are kept either on a 24-hour dial or as 1–12 with a PM flag in bit 7. The divider length defaults to 32768 base cycles per second.

An update does not land in one step. A status flag (`uip_o`) goes high a fixed number of base cycles before the second boundary. A sequencer then walks the fields from seconds up to year, one field per cycle, and passes a carry forward. The flag stays high for that whole walk, and the register outputs must be treated as unreliable while it is high.

Software loads a new time by raising a freeze input (`set_hold`). This stops counting, abandons any walk in progress, holds the divider at its half-way point and opens the single-field write port. When the freeze is released, the first second boundary arrives half a second later.

Top module: `cal_clock_engine`

## Requirements
- R1: Seconds and minutes each count 0 to 59; stepping past 59 gives 0 and carries into the next field.
- R2: In 24-hour mode (`fmt_24h`=1) hours count 0 to 23; stepping past 23 gives 0 and carries into the date.
- R3: In 12-hour mode (`fmt_24h`=0) the hours field holds 1–12 in bits 6:0, with bit 7 set for PM. Midnight reads 12 AM. Stepping from 12:59:59 AM gives 1 AM, and stepping from 11:59:59 gives 12:00:00 with bit 7 inverted. Leaving 11 PM carries into the date.
- R4: The day of month wraps to 1 after 31 in months 1, 3, 5, 7, 8, 10 and 12, after 30 in months 4, 6, 9 and 11, and in month 2 after 29 when the year is a multiple of 4 (00 included), otherwise after 28. A wrap carries into the month.
- R5: The weekday runs 1 to 7 and advances whenever the day of month advances, wrapping from 7 to 1.
- R6: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R7: When `fmt_binary`=0 every field is stored as two BCD digits (tens in bits 7:4). When it is 1, every field is stored as a plain binary number.
- R8: `uip_o` rises LEAD_CYCLES cycles before the second boundary and stays high through the six-cycle field walk, so a full update shows LEAD_CYCLES+6 consecutive high cycles. Counting changes a register only while `uip_o` is high.
- R9: While `set_hold` is 1, no field changes except by the write port and `uip_o` reads 0. A write (`wr_en`=1) loads `wr_data` into the field picked by `wr_field` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year; 7 selects nothing). When `set_hold` is 0, a write is ignored.
- R10: After `set_hold` falls, `uip_o` rises DIV_CYCLES/2 − LEAD_CYCLES cycles later. From then on, it rises every DIV_CYCLES cycles.
- R11: Raising `set_hold` while the field walk is running abandons the walk at once. A write given in that same cycle lands, and no later carry touches any field.
- R12: After reset the fields read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0, and `uip_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| set_hold | input | 1 | Freeze counting and open the write port |
| fmt_binary | input | 1 | 1 = binary storage, 0 = BCD storage |
| fmt_24h | input | 1 | 1 = 24-hour dial, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe (effective only under `set_hold`) |
| wr_field | input | 3 | Index of the field to write |
| wr_data | input | 8 | Value to write, in the current format |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field (bit 7 = PM in 12-hour mode) |
| wday_o | output | 8 | Weekday field |
| mday_o | output | 8 | Day-of-month field |
| mon_o | output | 8 | Month field |
| year_o | output | 8 | Two-digit year field |
| uip_o | output | 1 | Update in progress |

## Verification
Two functions can meet in one cycle: the field walk stepping seconds, and software freezing the engine while it writes that same field. The bench provokes this by timing from the observed rise of `uip_o`. It knows the walk reaches the seconds step exactly LEAD_CYCLES cycles after the rise, and in that cycle it raises `set_hold` together with a seconds write, starting from 59 seconds. The collision is judged correct only when the written value survives and the minutes and hours keep their old values well after the point where an unabandoned carry would have reached them.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEC,
        PH_MIN,
        PH_HOUR,
        PH_DAY,
        PH_MON,
        PH_YEAR
    } walk_phase_e;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } field_sel_e;

    localparam int WALK_STEPS = 6;

    localparam cal_time_t RESET_TIME = '{
        sec: 8'd0, min: 8'd0, hour: 8'd0, wday: 8'd1,
        mday: 8'd1, mon: 8'd1, year: 8'd0
    };

    // Packed two-digit BCD to binary.
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    // Binary (0..99) to packed two-digit BCD.
    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // Stored value to arithmetic value in the selected format.
    function automatic logic [7:0] fld_dec(input logic [7:0] v, input logic is_bin);
        return is_bin ? v : bcd_to_bin(v);
    endfunction

    function automatic logic [7:0] fld_enc(input logic [7:0] v, input logic is_bin);
        return is_bin ? v : bin_to_bcd(v);
    endfunction

    // Step with wrap: {wrapped, next}. Past 'top' restarts at 'first'.
    function automatic logic [8:0] step_wrap(input logic [7:0] v,
                                             input logic [7:0] top,
                                             input logic [7:0] first);
        if (v >= top)
            return {1'b1, first};
        return {1'b0, v + 8'd1};
    endfunction

    // Stored hour to 0..23.
    function automatic logic [7:0] hour_to_24(input logic [7:0] v,
                                              input logic is_bin,
                                              input logic dial_24);
        logic [7:0] h12;
        logic [7:0] base;
        if (dial_24)
            return fld_dec(v, is_bin);
        h12  = fld_dec({1'b0, v[6:0]}, is_bin);
        base = (h12 == 8'd12) ? 8'd0 : h12;
        return v[7] ? (base + 8'd12) : base;
    endfunction

    // 0..23 to stored hour.
    function automatic logic [7:0] hour_from_24(input logic [7:0] h,
                                                input logic is_bin,
                                                input logic dial_24);
        logic       pm;
        logic [7:0] h12;
        if (dial_24)
            return fld_enc(h, is_bin);
        pm  = (h >= 8'd12);
        h12 = pm ? (h - 8'd12) : h;
        if (h12 == 8'd0)
            h12 = 8'd12;
        return {pm, 7'd0} | fld_enc(h12, is_bin);
    endfunction

    // Last day of a month, arguments in binary.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] year);
        case (mon)
            8'd2:                       return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
            default:                    return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/cal_second_divider.sv
module cal_second_divider #(
    parameter int DIV_CYCLES  = 32768,
    parameter int LEAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic lead_o,
    output logic boundary_o
);
    localparam int CW = (DIV_CYCLES > 2) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST    = CW'(DIV_CYCLES - 1);
    localparam logic [CW-1:0] HALF    = CW'(DIV_CYCLES / 2);
    localparam logic [CW-1:0] LEAD_AT = CW'(DIV_CYCLES - LEAD_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (hold)
            cnt_q <= HALF;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign lead_o     = !hold && (cnt_q >= LEAD_AT);
    assign boundary_o = !hold && (cnt_q == LAST);

endmodule

// File: rtl/cal_field_walker.sv
module cal_field_walker
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       freeze,
    input  logic       is_bin,
    input  logic       dial_24,
    input  logic       wr_en,
    input  logic [2:0] wr_field,
    input  logic [7:0] wr_data,
    output cal_time_t  time_o,
    output logic       busy_o
);
    walk_phase_e phase_q, phase_d;
    logic        carry_q, carry_d;
    cal_time_t   t_q, t_d, t_wr;
    logic [8:0]  st_a, st_b;
    logic [7:0]  last_day;

    // Field stepping, one field per cycle.
    always_comb begin
        t_d      = t_q;
        carry_d  = 1'b0;
        phase_d  = phase_q;
        st_a     = '0;
        st_b     = '0;
        last_day = month_last_day(fld_dec(t_q.mon, is_bin), fld_dec(t_q.year, is_bin));
        unique case (phase_q)
            PH_IDLE: begin
                phase_d = start ? PH_SEC : PH_IDLE;
                carry_d = start;
            end
            PH_SEC: begin
                phase_d = PH_MIN;
                if (carry_q) begin
                    st_a     = step_wrap(fld_dec(t_q.sec, is_bin), 8'd59, 8'd0);
                    t_d.sec  = fld_enc(st_a[7:0], is_bin);
                    carry_d  = st_a[8];
                end
            end
            PH_MIN: begin
                phase_d = PH_HOUR;
                if (carry_q) begin
                    st_a     = step_wrap(fld_dec(t_q.min, is_bin), 8'd59, 8'd0);
                    t_d.min  = fld_enc(st_a[7:0], is_bin);
                    carry_d  = st_a[8];
                end
            end
            PH_HOUR: begin
                phase_d = PH_DAY;
                if (carry_q) begin
                    st_a     = step_wrap(hour_to_24(t_q.hour, is_bin, dial_24), 8'd23, 8'd0);
                    t_d.hour = hour_from_24(st_a[7:0], is_bin, dial_24);
                    carry_d  = st_a[8];
                end
            end
            PH_DAY: begin
                phase_d = PH_MON;
                if (carry_q) begin
                    st_a     = step_wrap(fld_dec(t_q.mday, is_bin), last_day, 8'd1);
                    st_b     = step_wrap(fld_dec(t_q.wday, is_bin), 8'd7, 8'd1);
                    t_d.mday = fld_enc(st_a[7:0], is_bin);
                    t_d.wday = fld_enc(st_b[7:0], is_bin);
                    carry_d  = st_a[8];
                end
            end
            PH_MON: begin
                phase_d = PH_YEAR;
                if (carry_q) begin
                    st_a     = step_wrap(fld_dec(t_q.mon, is_bin), 8'd12, 8'd1);
                    t_d.mon  = fld_enc(st_a[7:0], is_bin);
                    carry_d  = st_a[8];
                end
            end
            PH_YEAR: begin
                phase_d = PH_IDLE;
                if (carry_q) begin
                    st_a     = step_wrap(fld_dec(t_q.year, is_bin), 8'd99, 8'd0);
                    t_d.year = fld_enc(st_a[7:0], is_bin);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Software load of one field.
    always_comb begin
        t_wr = t_q;
        case (field_sel_e'(wr_field))
            FLD_SEC:  t_wr.sec  = wr_data;
            FLD_MIN:  t_wr.min  = wr_data;
            FLD_HOUR: t_wr.hour = wr_data;
            FLD_WDAY: t_wr.wday = wr_data;
            FLD_MDAY: t_wr.mday = wr_data;
            FLD_MON:  t_wr.mon  = wr_data;
            FLD_YEAR: t_wr.year = wr_data;
            default:  t_wr      = t_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            carry_q <= 1'b0;
            t_q     <= RESET_TIME;
        end else if (freeze) begin
            phase_q <= PH_IDLE;
            carry_q <= 1'b0;
            if (wr_en)
                t_q <= t_wr;
        end else begin
            phase_q <= phase_d;
            carry_q <= carry_d;
            t_q     <= t_d;
        end
    end

    assign time_o = t_q;
    assign busy_o = (phase_q != PH_IDLE);

endmodule

// File: rtl/cal_clock_engine.sv
module cal_clock_engine
    import cal_pkg::*;
#(
    parameter int DIV_CYCLES  = 32768,
    parameter int LEAD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_hold,
    input  logic       fmt_binary,
    input  logic       fmt_24h,
    input  logic       wr_en,
    input  logic [2:0] wr_field,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o
);
    logic      lead;
    logic      boundary;
    logic      busy;
    cal_time_t now;

    cal_second_divider #(
        .DIV_CYCLES (DIV_CYCLES),
        .LEAD_CYCLES(LEAD_CYCLES)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .hold      (set_hold),
        .lead_o    (lead),
        .boundary_o(boundary)
    );

    cal_field_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (boundary),
        .freeze  (set_hold),
        .is_bin  (fmt_binary),
        .dial_24 (fmt_24h),
        .wr_en   (wr_en),
        .wr_field(wr_field),
        .wr_data (wr_data),
        .time_o  (now),
        .busy_o  (busy)
    );

    assign uip_o  = lead | busy;
    assign sec_o  = now.sec;
    assign min_o  = now.min;
    assign hour_o = now.hour;
    assign wday_o = now.wday;
    assign mday_o = now.mday;
    assign mon_o  = now.mon;
    assign year_o = now.year;

endmodule

// File: rtl/cal_clock_engine_chk.sv
module cal_clock_engine_chk #(
    parameter int LEAD_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       set_hold,
    input logic       wr_en,
    input logic       uip_o,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o
);
    localparam int MAX_RUN = LEAD_CYCLES + cal_pkg::WALK_STEPS;

    logic [55:0] fields;
    logic [31:0] run_q;

    assign fields = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (uip_o)
            run_q <= run_q + 32'd1;
        else
            run_q <= '0;
    end

    // R8: counting only moves fields while the flag was up
    p_change_under_uip_r8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(fields) && !$past(set_hold)) |-> $past(uip_o));

    // R8: flag high period bounded by lead plus walk
    p_uip_length_r8: assert property (@(posedge clk) disable iff (rst)
        uip_o |-> (run_q < MAX_RUN));

    // R9: frozen fields change only through a write
    p_freeze_stable_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(set_hold) && !$past(wr_en)) |-> $stable(fields));

    // R9: no update flag while frozen
    p_freeze_no_uip_r9: assert property (@(posedge clk) disable iff (rst)
        $past(set_hold) |-> !uip_o);

    // R5: a counted date change always moves the weekday
    p_wday_with_date_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mday_o) && $past(uip_o) && !$past(set_hold)) |-> !$stable(wday_o));

endmodule

bind cal_clock_engine cal_clock_engine_chk #(.LEAD_CYCLES(LEAD_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .set_hold(set_hold),
    .wr_en   (wr_en),
    .uip_o   (uip_o),
    .sec_o   (sec_o),
    .min_o   (min_o),
    .hour_o  (hour_o),
    .wday_o  (wday_o),
    .mday_o  (mday_o),
    .mon_o   (mon_o),
    .year_o  (year_o)
);

// File: tb/cal_clock_engine_bench.sv
module cal_clock_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;
    localparam int LEAD       = 3;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 12;

    // {binary, dial24, init sec..year, expected sec..year}
    localparam logic [113:0] VEC [NV] = '{
        // R1 R7: BCD digit carry 09 -> 10
        {1'b0, 1'b1, 8'h09, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h23,
                     8'h10, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h23},
        // R1: seconds and minutes carry into hours
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h10, 8'h02, 8'h05, 8'h03, 8'h23,
                     8'h00, 8'h00, 8'h11, 8'h02, 8'h05, 8'h03, 8'h23},
        // R2 R4 R5: 30-day month rolls, weekday 7 -> 1
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h06, 8'h23,
                     8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h07, 8'h23},
        // R6: year 99 -> 00
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99,
                     8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00},
        // R4: leap February 28 -> 29
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24,
                     8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24},
        // R4: common February 28 -> March 1
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23,
                     8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h23},
        // R4: 31-day month does not wrap at 30
        {1'b0, 1'b1, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23,
                     8'h00, 8'h00, 8'h00, 8'h02, 8'h31, 8'h01, 8'h23},
        // R3: 11:59:59 AM -> 12 PM
        {1'b0, 1'b0, 8'h59, 8'h59, 8'h11, 8'h03, 8'h10, 8'h05, 8'h23,
                     8'h00, 8'h00, 8'h92, 8'h03, 8'h10, 8'h05, 8'h23},
        // R3: 12:59:59 AM -> 1 AM
        {1'b0, 1'b0, 8'h59, 8'h59, 8'h12, 8'h03, 8'h10, 8'h05, 8'h23,
                     8'h00, 8'h00, 8'h01, 8'h03, 8'h10, 8'h05, 8'h23},
        // R3 R5: 11 PM -> 12 AM, next day
        {1'b0, 1'b0, 8'h59, 8'h59, 8'h91, 8'h07, 8'h31, 8'h01, 8'h23,
                     8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h02, 8'h23},
        // R7 R6: binary, full rollover
        {1'b1, 1'b1, 8'h3B, 8'h3B, 8'h17, 8'h07, 8'h1F, 8'h0C, 8'h63,
                     8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00},
        // R7 R3: binary 12-hour, 12:59:59 PM -> 1 PM
        {1'b1, 1'b0, 8'h3B, 8'h3B, 8'h8C, 8'h02, 8'h0A, 8'h03, 8'h18,
                     8'h00, 8'h00, 8'h81, 8'h02, 8'h0A, 8'h03, 8'h18}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_hold = 1'b0;
    logic       fmt_binary = 1'b0;
    logic       fmt_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_field = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
    logic       uip_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_clock_engine #(
        .DIV_CYCLES (DIV),
        .LEAD_CYCLES(LEAD)
    ) u_cal_clock_engine (
        .clk(clk), .rst(rst), .set_hold(set_hold), .fmt_binary(fmt_binary),
        .fmt_24h(fmt_24h), .wr_en(wr_en), .wr_field(wr_field), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o), .uip_o(uip_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_field(input logic [2:0] f, input logic [7:0] d);
        wr_en = 1'b1; wr_field = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_update_done();
        for (int k = 0; k < 200 && !uip_o; k++) @(negedge clk);
        for (int k = 0; k < 50 && uip_o; k++) @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        logic [113:0] v;
        logic [55:0]  got;
        v = VEC[i];
        @(negedge clk);
        set_hold = 1'b1; fmt_binary = v[113]; fmt_24h = v[112];
        for (int f = 0; f < 7; f++) write_field(3'(f), v[111-8*f -: 8]);
        set_hold = 1'b0;
        wait_update_done();
        got = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
        check(got == v[55:0], $sformatf("vector %0d (R1..R7)", i), 64'(got), 64'(v[55:0]));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        logic ok_frz;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, uip_o} ==
              {56'h00_00_00_01_01_01_00, 1'b0}, "R12 reset state",
              64'({sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, uip_o}),
              64'({56'h00_00_00_01_01_01_00, 1'b0}));

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: delay from release to flag, R8 flag length, R10 period
        fmt_binary = 1'b0; fmt_24h = 1'b1;
        @(negedge clk); set_hold = 1'b1;
        @(negedge clk); set_hold = 1'b0;
        n = 0;
        for (int k = 0; k < 100 && !uip_o; k++) begin @(negedge clk); n++; end
        check(n == DIV/2 - LEAD, "R10 release-to-uip delay", 64'(n), 64'(DIV/2 - LEAD));
        n = 0;
        for (int k = 0; k < 100 && uip_o; k++) begin @(negedge clk); n++; end
        check(n == LEAD + 6, "R8 uip high length", 64'(n), 64'(LEAD + 6));
        for (int k = 0; k < 100 && !uip_o; k++) begin @(negedge clk); n++; end
        check(n == DIV, "R10 uip period", 64'(n), 64'(DIV));

        // R9: frozen for several seconds
        @(negedge clk); set_hold = 1'b1;
        write_field(3'd0, 8'h20);
        ok_frz = 1'b1;
        for (int k = 0; k < 3*DIV; k++) begin
            @(negedge clk);
            if (uip_o || sec_o != 8'h20) ok_frz = 1'b0;
        end
        check(ok_frz, "R9 freeze holds seconds, uip low", 64'({uip_o, sec_o}), 64'h20);

        // R9: write ignored when not frozen
        write_field(3'd0, 8'h10);
        write_field(3'd1, 8'h20);
        set_hold = 1'b0;
        write_field(3'd1, 8'h45);
        @(negedge clk);
        check(min_o == 8'h20, "R9 write ignored without freeze", 64'(min_o), 64'h20);

        // R11: freeze plus write in the cycle the walk steps seconds
        @(negedge clk); set_hold = 1'b1;
        write_field(3'd0, 8'h59);
        write_field(3'd1, 8'h10);
        write_field(3'd2, 8'h05);
        set_hold = 1'b0;
        for (int k = 0; k < 100 && !uip_o; k++) @(negedge clk);
        repeat (LEAD) @(negedge clk);
        set_hold = 1'b1;
        write_field(3'd0, 8'h30);
        check(sec_o == 8'h30, "R11 write wins over seconds step", 64'(sec_o), 64'h30);
        repeat (10) @(negedge clk);
        check({min_o, hour_o} == 16'h1005, "R11 walk abandoned, no carry",
              64'({min_o, hour_o}), 64'h1005);
        set_hold = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule